// File: doc/BRIEF.md
# Flagged Character I/O with Interrupt Request

This block sits between a byte-wide input device, a byte-wide output device and a small accumulator processor. Each direction has one data register and one ready flag. The device and the processor take turns on that flag. On the input side, the device deposits a byte and raises the flag, and the processor collects the byte and drops the flag. On the output side, the processor deposits a byte and drops the flag, and the device consumes the byte and raises the flag again.

The processor talks to the block through decoded single-cycle strobes. The strobes read the input byte, write the output byte, test either flag for a skip, and turn interrupts on or off. The block also receives the processor's timing phase, and a pulse when the processor finishes its interrupt cycle. A pending-interrupt flag is raised once interrupts are enabled and a flag is set, but only outside the fetch phases. The processor's interrupt cycle then clears both the pending flag and the enable.

Top module: `char_io_irq`

## Requirements
- R1: After reset, dev_in_ready is 1, dev_out_valid is 0, skip_req is 0 and irq_pend is 0. This means the input flag is 0, the output flag is 1, and interrupts are disabled.
- R2: When dev_in_valid is high and the input flag is 0, the byte is captured at the clock edge and the input flag becomes 1. dev_in_ready is the inverse of the input flag. While the flag is 1 the device stalls, and the held byte is not overwritten.
- R3: in_char always shows the held input byte. When in_stb is high at an edge with no device load in that cycle, the input flag is cleared.
- R4: When out_stb is high at an edge, dev_out_data takes acc_lo and the output flag is cleared. dev_out_valid is the inverse of the output flag.
- R5: dev_out_ack while the output flag is 0 sets the flag to 1. out_stb in the same cycle takes priority. dev_out_ack while the flag is 1 has no effect.
- R6: skip_req is high, combinationally, when ski_stb is high and the input flag is 1, or when sko_stb is high and the output flag is 1. Otherwise it is low.
- R7: ien_on sets the interrupt enable and ien_off clears it. Only the effect on irq_pend is visible.
- R8: irq_pend becomes 1 at the edge that follows a cycle where all three of these hold: the enable is 1, either flag is 1, and phase is 3 or above (that is, not 0, 1 or 2). Once set, it stays set until irq_done.
- R9: irq_done clears both irq_pend and the enable at the next edge, and takes priority over any set condition.
- R10: If a device load and in_stb meet in the same cycle, the device load wins and the input flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stb | input | 1 | Processor reads the input byte |
| out_stb | input | 1 | Processor writes the output byte |
| ski_stb | input | 1 | Skip-if-input-flag test |
| sko_stb | input | 1 | Skip-if-output-flag test |
| ien_on | input | 1 | Enable interrupts |
| ien_off | input | 1 | Disable interrupts |
| phase | input | 4 | Current timing phase index |
| irq_done | input | 1 | Interrupt cycle complete pulse |
| acc_lo | input | 8 | Low accumulator byte |
| in_char | output | 8 | Held input byte |
| skip_req | output | 1 | Request to increment the program counter |
| irq_pend | output | 1 | Interrupt pending |
| dev_in_valid | input | 1 | Device offers an input byte |
| dev_in_data | input | 8 | Device input byte |
| dev_in_ready | output | 1 | Block can take an input byte |
| dev_out_valid | output | 1 | Output byte waiting for the device |
| dev_out_data | output | 8 | Output byte |
| dev_out_ack | input | 1 | Device consumed the output byte |

## Verification
The assertions take for granted that the processor strobes are decoded from a single instruction, so that at most one of in_stb, out_stb, ski_stb, sko_stb, ien_on and ien_off is high in any cycle. They also expect irq_done to be a single-cycle pulse. The stimulus picks at most one strobe per cycle from $urandom, and it drives device valid, device ack, irq_done and the phase freely. Directed sequences cover the stall, the same-cycle load versus read, and the clearing by irq_done.

// File: rtl/char_io_pkg.sv
package char_io_pkg;
  // true when the phase lies past the fetch phases, i.e. interrupt sampling is allowed
  function automatic logic past_fetch(input int unsigned ph, input int unsigned fetch_n);
    return ph >= fetch_n;
  endfunction

  // next value of the input flag: device load wins over processor read
  function automatic logic next_in_flag(input logic flag, input logic load, input logic rd);
    if (load) return 1'b1;
    if (rd) return 1'b0;
    return flag;
  endfunction

  // next value of the output flag: processor write wins over device ack
  function automatic logic next_out_flag(input logic flag, input logic wr, input logic ack);
    if (wr) return 1'b0;
    if (ack && !flag) return 1'b1;
    return flag;
  endfunction
endpackage

// File: rtl/char_io_in_chan.sv
module char_io_in_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_valid,
  input  logic [DW-1:0] dev_data,
  input  logic          rd_stb,
  output logic          dev_ready,
  output logic          flag,
  output logic [DW-1:0] data
);
  import char_io_pkg::*;

  logic load_ev;
  assign load_ev   = dev_valid && !flag;
  assign dev_ready = !flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      data <= '0;
    end else begin
      flag <= next_in_flag(flag, load_ev, rd_stb);
      if (load_ev) data <= dev_data;
    end
  end

  p_load_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && dev_ready) |=> (flag && data == $past(dev_data)));
  p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(data));
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(dev_valid && dev_ready)) |=> !flag);
  p_load_beats_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && dev_valid && dev_ready) |=> flag);
endmodule

// File: rtl/char_io_out_chan.sv
module char_io_out_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          dev_ack,
  output logic          dev_valid,
  output logic          flag,
  output logic [DW-1:0] data
);
  import char_io_pkg::*;

  assign dev_valid = !flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b1;
      data <= '0;
    end else begin
      flag <= next_out_flag(flag, wr_stb, dev_ack);
      if (wr_stb) data <= wr_data;
    end
  end

  p_write_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (!flag && data == $past(wr_data)));
  p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && dev_valid && !wr_stb) |=> flag);
  p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_stb) |=> (flag && $stable(data)));
endmodule

// File: rtl/char_io_irq_ctl.sv
module char_io_irq_ctl #(
  parameter int PW      = 4,
  parameter int FETCH_N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_stb,
  input  logic          off_stb,
  input  logic          done,
  input  logic [PW-1:0] phase,
  input  logic          in_flag,
  input  logic          out_flag,
  output logic          ien,
  output logic          pend
);
  import char_io_pkg::*;

  logic set_ev;
  assign set_ev = ien && (in_flag || out_flag) && past_fetch(int'(phase), FETCH_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (done || off_stb) ien <= 1'b0;
      else if (on_stb)     ien <= 1'b1;
      if (done)            pend <= 1'b0;
      else if (set_ev)     pend <= 1'b1;
    end
  end

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!pend && !ien));
  p_request_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && (in_flag || out_flag) && phase >= PW'(FETCH_N) && !done) |=> pend);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !done) |=> pend);
  p_no_req_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && phase < PW'(FETCH_N)) |=> !pend);
  p_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (on_stb && !off_stb && !done) |=> ien);
endmodule

// File: rtl/char_io_irq.sv
module char_io_irq #(
  parameter int DW      = 8,
  parameter int PW      = 4,
  parameter int FETCH_N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_stb,
  input  logic          out_stb,
  input  logic          ski_stb,
  input  logic          sko_stb,
  input  logic          ien_on,
  input  logic          ien_off,
  input  logic [PW-1:0] phase,
  input  logic          irq_done,
  input  logic [DW-1:0] acc_lo,
  output logic [DW-1:0] in_char,
  output logic          skip_req,
  output logic          irq_pend,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ack
);
  logic in_flag_w, out_flag_w, ien_w;

  char_io_in_chan #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .dev_valid(dev_in_valid), .dev_data(dev_in_data),
    .rd_stb(in_stb), .dev_ready(dev_in_ready), .flag(in_flag_w), .data(in_char)
  );

  char_io_out_chan #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_stb(out_stb), .wr_data(acc_lo),
    .dev_ack(dev_out_ack), .dev_valid(dev_out_valid), .flag(out_flag_w),
    .data(dev_out_data)
  );

  char_io_irq_ctl #(.PW(PW), .FETCH_N(FETCH_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .on_stb(ien_on), .off_stb(ien_off), .done(irq_done),
    .phase(phase), .in_flag(in_flag_w), .out_flag(out_flag_w),
    .ien(ien_w), .pend(irq_pend)
  );

  assign skip_req = (ski_stb && in_flag_w) || (sko_stb && out_flag_w);

  p_skip_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> (ski_stb || sko_stb));
  p_skip_in_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ski_stb && !sko_stb && skip_req) |-> !dev_in_ready);
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (dev_in_ready && !dev_out_valid && !irq_pend));
endmodule

// File: tb/char_io_irq_tb_top.sv
`timescale 1ns/1ps
module char_io_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_stb = 0, out_stb = 0, ski_stb = 0, sko_stb = 0, ien_on = 0, ien_off = 0;
  logic [3:0] phase = '0;
  logic irq_done = 0;
  logic [7:0] acc_lo = '0;
  logic [7:0] in_char;
  logic skip_req, irq_pend;
  logic dev_in_valid = 0;
  logic [7:0] dev_in_data = '0;
  logic dev_in_ready, dev_out_valid;
  logic [7:0] dev_out_data;
  logic dev_out_ack = 0;

  int n_cmp = 0, n_bad = 0;
  logic m_fgi, m_fgo, m_ien, m_r;
  logic [7:0] m_inpr, m_outr;

  always #5 clk = ~clk;

  char_io_irq dut_i (
    .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .out_stb(out_stb), .ski_stb(ski_stb),
    .sko_stb(sko_stb), .ien_on(ien_on), .ien_off(ien_off), .phase(phase),
    .irq_done(irq_done), .acc_lo(acc_lo), .in_char(in_char), .skip_req(skip_req),
    .irq_pend(irq_pend), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ack(dev_out_ack)
  );

  function automatic logic exp_skip(logic ski, logic sko, logic fi, logic fo);
    return (ski & fi) | (sko & fo);
  endfunction

  function automatic logic exp_r(logic r, logic done, logic ien, logic fi, logic fo, logic [3:0] ph);
    if (done) return 1'b0;
    return r | (ien & (fi | fo) & (ph > 4'd2));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge; check combinational and state outputs; advance model at posedge
  task automatic step();
    logic ld;
    #1;
    chk("R2 ready", {7'd0, dev_in_ready}, {7'd0, !m_fgi});
    chk("R3 in_char", in_char, m_inpr);
    chk("R4 out_valid", {7'd0, dev_out_valid}, {7'd0, !m_fgo});
    chk("R4 out_data", dev_out_data, m_outr);
    chk("R6 skip", {7'd0, skip_req}, {7'd0, exp_skip(ski_stb, sko_stb, m_fgi, m_fgo)});
    chk("R8 irq_pend", {7'd0, irq_pend}, {7'd0, m_r});
    ld = dev_in_valid & !m_fgi;
    @(posedge clk);
    m_r    = exp_r(m_r, irq_done, m_ien, m_fgi, m_fgo, phase);
    m_ien  = irq_done ? 1'b0 : ien_off ? 1'b0 : ien_on ? 1'b1 : m_ien;
    if (ld) m_inpr = dev_in_data;
    m_fgi  = ld ? 1'b1 : in_stb ? 1'b0 : m_fgi;
    if (out_stb) m_outr = acc_lo;
    m_fgo  = out_stb ? 1'b0 : (dev_out_ack && !m_fgo) ? 1'b1 : m_fgo;
    @(negedge clk);
  endtask

  task automatic idle();
    {in_stb, out_stb, ski_stb, sko_stb, ien_on, ien_off, irq_done, dev_in_valid, dev_out_ack} = '0;
    phase = 4'd0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_fgi = 0; m_fgo = 1; m_ien = 0; m_r = 0; m_inpr = 0; m_outr = 0;
    repeat (3) @(negedge clk);
    // R1: reset values seen while reset asserted and just after release
    #1;
    chk("R1 ready", {7'd0, dev_in_ready}, 8'd1);
    chk("R1 out_valid", {7'd0, dev_out_valid}, 8'd0);
    chk("R1 irq_pend", {7'd0, irq_pend}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: load, then stall with a different byte that must not land
    dev_in_valid = 1; dev_in_data = 8'hA5; step();
    dev_in_data = 8'h3C; step(); step();
    chk("R2 held byte", in_char, 8'hA5);
    // R6: skip on input flag
    idle(); ski_stb = 1; step();
    // R10: in_stb plus new load in same cycle after reading
    idle(); in_stb = 1; step();
    idle(); in_stb = 1; dev_in_valid = 1; dev_in_data = 8'h77; step();
    idle(); step();
    chk("R10 flag kept", {7'd0, dev_in_ready}, 8'd0);
    // R4/R5: write, ack, ack when idle
    idle(); out_stb = 1; acc_lo = 8'h5A; step();
    idle(); sko_stb = 1; step();
    idle(); dev_out_ack = 1; step(); step();
    // R7/R8: enable, request only outside fetch phases
    idle(); ien_on = 1; step();
    idle(); phase = 4'd1; step(); phase = 4'd2; step();
    chk("R8 none in fetch", {7'd0, irq_pend}, 8'd0);
    phase = 4'd3; step(); idle(); step();
    chk("R8 raised", {7'd0, irq_pend}, 8'd1);
    // R9: done clears pend and enable
    irq_done = 1; step(); idle(); phase = 4'd5; step(); step();
    chk("R9 stays clear", {7'd0, irq_pend}, 8'd0);
    // R7: off keeps it clear
    idle(); ien_on = 1; step(); idle(); ien_off = 1; step(); idle(); phase = 4'd6; step(); step();
    chk("R7 off", {7'd0, irq_pend}, 8'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      idle();
      case ($urandom % 10)
        0: in_stb = 1;
        1: out_stb = 1;
        2: ski_stb = 1;
        3: sko_stb = 1;
        4: ien_on = ($urandom % 3) == 0;
        5: ien_off = ($urandom % 4) == 0;
        default: ;
      endcase
      phase        = 4'($urandom % 8);
      irq_done     = ($urandom % 12) == 0;
      acc_lo       = 8'($urandom);
      dev_in_valid = ($urandom % 3) == 0;
      dev_in_data  = 8'($urandom);
      dev_out_ack  = ($urandom % 3) == 0;
      step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule